// File: doc/BRIEF.md
# CAN Controller Mode Sequencer

This block decides which operating mode a CAN protocol controller is in and tells the rest of the controller what that mode allows. It has five modes: initialization (the mode after any reset), active (normal bus traffic), doze (a low-power wait with clocks still running), deep doze (the bus interface clock stopped), and bus-off (disconnected after too many transmit errors). Software drives it through three request bits: enter initialization, enter doze, and force recovery from bus-off. It also takes a clock-stop control. The transmit path supplies a busy flag, an end-of-frame pulse and the transmit error count. The bit-level receiver supplies a pulse each time it sees eleven recessive bits in a row.

The outputs tell the rest of the controller what to do. Two status flags report the initialization and bus-off modes. A one-cycle strobe clears the status, interrupt-control, error-counter and timestamp registers and the per-mailbox control registers. A lock signal blocks processor writes to those same registers. A communication enable lets the protocol engine drive and sample the bus. Two rules shape the sequencing. A request to enter initialization never cuts off a frame that is already being sent. Recovery from bus-off needs 128 separate sightings of an idle bus unless software forces it.

Every mode change takes effect on a rising clock edge. All outputs are registered, and they change on the same edge as the mode. Reset is synchronous and active high.

Top module: `can_mode_seq`

## Requirements
- R1: While `rst` is high, and after the first clock edge that samples it, `stat_init`=1, `wr_lock`=1, `regs_clr`=1, `comm_en`=0 and `stat_busoff`=0.
- R2: In initialization mode, a clock edge that samples `req_init`=0 and `req_doze`=0 moves the block to active mode. After that edge `comm_en`=1, `stat_init`=0 and `wr_lock`=0.
- R3: In active mode, with no frame being sent (`tx_busy`=0) and `req_init`=1, the next edge enters initialization mode. `stat_init` and `wr_lock` go to 1, and `regs_clr` is 1 for exactly that one cycle.
- R4: In active mode, while `req_init`=1, `tx_busy`=1 and `tx_end`=0, the block stays active with `comm_en`=1. The edge that samples `tx_end`=1 enters initialization mode.
- R5: In initialization mode, an edge that samples `req_doze`=1 and `req_init`=0 enters doze mode. In doze mode `stat_init`, `stat_busoff` and `comm_en` are all 0.
- R6: In doze mode, an edge that samples `req_init`=1 and `req_doze`=0 enters initialization mode directly.
- R7: In doze mode, `clk_stop`=1 enters deep doze. Deep doze ignores `req_init` (`stat_init` stays 0) until an edge samples `clk_stop`=0, which returns the block to doze mode.
- R8: In active mode, a transmit error count `tec` above 255 enters bus-off on the next edge (`stat_busoff`=1, `comm_en`=0). A count of exactly 255 does not. Bus-off entry takes priority over `req_init`.
- R9: In bus-off, each cycle with `idle11`=1 counts one sighting. The edge that samples the 128th sighting returns the block to active mode. After 127 sightings it is still in bus-off.
- R10: In bus-off, `req_boff_exit`=1 returns the block to active mode on the next edge, whatever the sighting count.
- R11: In bus-off, `req_init`=1 enters initialization mode on the next edge, ahead of any recovery. The sighting count is cleared on entry to initialization mode and on every entry to bus-off.
- R12: At most one of `stat_init`, `stat_busoff` and `comm_en` is 1 at any time. `regs_clr` is 1 only in a cycle where `stat_init` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_init | input | 1 | Software request for initialization mode |
| req_doze | input | 1 | Software request for doze mode |
| req_boff_exit | input | 1 | Software override to leave bus-off |
| clk_stop | input | 1 | Bus interface clock stop control |
| tx_busy | input | 1 | A frame is being transmitted |
| tx_end | input | 1 | Pulse: the transmission ended (success, lost arbitration or error) |
| tec | input | TEC_W | Transmit error count |
| idle11 | input | 1 | Pulse: eleven consecutive recessive bits seen |
| stat_init | output | 1 | Initialization mode status flag |
| stat_busoff | output | 1 | Bus-off status flag |
| regs_clr | output | 1 | Clear strobe for the status and error registers |
| wr_lock | output | 1 | Processor write lock for the cleared registers |
| comm_en | output | 1 | Bus communication enabled |

## Verification
The properties assume that `tx_end` appears only while `tx_busy` is high. They also assume that `tec` stays in range and changes only through the error logic, so that the bus-off entry and transmit-wait properties reflect real traffic. The bench honours this: it raises `tx_end` only during a held `tx_busy`, it drives `tec` above the limit only to provoke bus-off, and it returns `tec` to zero before recovery. The deep doze and doze modes look the same at the ports, so the bench tells them apart by observing how each one answers a later initialization request.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  typedef enum logic [2:0] {
    MD_INIT   = 3'd0,
    MD_ACTIVE = 3'd1,
    MD_DOZE   = 3'd2,
    MD_DEEP   = 3'd3,
    MD_BUSOFF = 3'd4
  } mode_t;

endpackage

// File: rtl/can_idle_counter.sv
module can_idle_counter #(
  parameter int SIGHTINGS = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = (SIGHTINGS > 2) ? $clog2(SIGHTINGS) : 1;
  localparam logic [CW-1:0] LAST_VAL = CW'(SIGHTINGS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc && (cnt != LAST_VAL)) begin
      cnt <= cnt + 1'b1;
    end
  end

  // terminal-count detect: the current sighting is the final one
  assign last = (cnt == LAST_VAL);

endmodule

// File: rtl/can_mode_next.sv
module can_mode_next
  import can_mode_pkg::*;
(
  input  mode_t mode,
  input  logic  req_init,
  input  logic  req_doze,
  input  logic  req_boff_exit,
  input  logic  clk_stop,
  input  logic  tx_busy,
  input  logic  tx_end,
  input  logic  tec_over,
  input  logic  idle11,
  input  logic  idle_last,
  output mode_t nxt
);

  always_comb begin
    nxt = mode;
    unique case (mode)
      MD_INIT: begin
        if (!req_init && !req_doze)     nxt = MD_ACTIVE;
        else if (!req_init && req_doze) nxt = MD_DOZE;
      end
      MD_ACTIVE: begin
        if (tec_over)                           nxt = MD_BUSOFF;
        else if (req_init && (!tx_busy || tx_end)) nxt = MD_INIT;
      end
      MD_DOZE: begin
        if (req_init && !req_doze) nxt = MD_INIT;
        else if (clk_stop)         nxt = MD_DEEP;
      end
      MD_DEEP: begin
        if (!clk_stop) nxt = MD_DOZE;
      end
      MD_BUSOFF: begin
        if (req_init)                    nxt = MD_INIT;
        else if (req_boff_exit)          nxt = MD_ACTIVE;
        else if (idle11 && idle_last)    nxt = MD_ACTIVE;
      end
      default: nxt = MD_INIT;
    endcase
  end

endmodule

// File: rtl/can_mode_regs.sv
module can_mode_regs
  import can_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_t nxt,
  output mode_t mode,
  output logic  stat_init,
  output logic  stat_busoff,
  output logic  regs_clr,
  output logic  wr_lock,
  output logic  comm_en
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode        <= MD_INIT;
      stat_init   <= 1'b1;
      stat_busoff <= 1'b0;
      regs_clr    <= 1'b1;
      wr_lock     <= 1'b1;
      comm_en     <= 1'b0;
    end else begin
      mode        <= nxt;
      stat_init   <= (nxt == MD_INIT);
      stat_busoff <= (nxt == MD_BUSOFF);
      regs_clr    <= (nxt == MD_INIT) && (mode != MD_INIT);
      wr_lock     <= (nxt == MD_INIT);
      comm_en     <= (nxt == MD_ACTIVE);
    end
  end

endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int TEC_W     = 9,
  parameter int TEC_LIMIT = 255,
  parameter int SIGHTINGS = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_init,
  input  logic             req_doze,
  input  logic             req_boff_exit,
  input  logic             clk_stop,
  input  logic             tx_busy,
  input  logic             tx_end,
  input  logic [TEC_W-1:0] tec,
  input  logic             idle11,
  output logic             stat_init,
  output logic             stat_busoff,
  output logic             regs_clr,
  output logic             wr_lock,
  output logic             comm_en
);
  localparam logic [TEC_W-1:0] TEC_MAX = TEC_W'(TEC_LIMIT);

  mode_t mode;
  mode_t nxt;
  logic  tec_over;
  logic  idle_last;
  logic  cnt_clr;
  logic  cnt_inc;

  assign tec_over = (tec > TEC_MAX);
  assign cnt_clr  = (nxt == MD_INIT) ||
                    ((nxt == MD_BUSOFF) && (mode != MD_BUSOFF));
  assign cnt_inc  = (mode == MD_BUSOFF) && idle11;

  can_idle_counter #(.SIGHTINGS(SIGHTINGS)) u_idle (
    .clk  (clk),
    .rst  (rst),
    .clr  (cnt_clr),
    .inc  (cnt_inc),
    .last (idle_last)
  );

  can_mode_next u_next (
    .mode          (mode),
    .req_init      (req_init),
    .req_doze      (req_doze),
    .req_boff_exit (req_boff_exit),
    .clk_stop      (clk_stop),
    .tx_busy       (tx_busy),
    .tx_end        (tx_end),
    .tec_over      (tec_over),
    .idle11        (idle11),
    .idle_last     (idle_last),
    .nxt           (nxt)
  );

  can_mode_regs u_regs (
    .clk         (clk),
    .rst         (rst),
    .nxt         (nxt),
    .mode        (mode),
    .stat_init   (stat_init),
    .stat_busoff (stat_busoff),
    .regs_clr    (regs_clr),
    .wr_lock     (wr_lock),
    .comm_en     (comm_en)
  );

endmodule

// File: rtl/can_mode_seq_chk.sv
module can_mode_seq_chk #(
  parameter int TEC_W     = 9,
  parameter int TEC_LIMIT = 255
) (
  input logic             clk,
  input logic             rst,
  input logic             req_init,
  input logic             req_doze,
  input logic             req_boff_exit,
  input logic             tx_busy,
  input logic             tx_end,
  input logic [TEC_W-1:0] tec,
  input logic             stat_init,
  input logic             stat_busoff,
  input logic             regs_clr,
  input logic             comm_en
);
  localparam logic [TEC_W-1:0] TEC_MAX = TEC_W'(TEC_LIMIT);

  // R2
  leave_init_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_init && !req_init && !req_doze) |=> comm_en);

  // R4
  tx_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (comm_en && req_init && tx_busy && !tx_end && (tec <= TEC_MAX)) |=> comm_en);

  // R8
  busoff_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (comm_en && (tec > TEC_MAX)) |=> (stat_busoff && !comm_en));

  // R10
  forced_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_busoff && req_boff_exit && !req_init) |=> comm_en);

  // R11
  busoff_init_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_busoff && req_init) |=> stat_init);

  // R12
  flags_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stat_init, stat_busoff, comm_en}));

  // R12
  clr_in_init_chk: assert property (@(posedge clk) disable iff (rst)
    regs_clr |-> stat_init);

  // R3
  clr_on_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_init) |-> regs_clr);

endmodule

bind can_mode_seq can_mode_seq_chk #(.TEC_W(TEC_W), .TEC_LIMIT(TEC_LIMIT)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_init      (req_init),
  .req_doze      (req_doze),
  .req_boff_exit (req_boff_exit),
  .tx_busy       (tx_busy),
  .tx_end        (tx_end),
  .tec           (tec),
  .stat_init     (stat_init),
  .stat_busoff   (stat_busoff),
  .regs_clr      (regs_clr),
  .comm_en       (comm_en)
);

// File: tb/tb_can_mode_seq.sv
module tb_can_mode_seq;
  localparam int TEC_W = 9;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_init = 1'b1;
  logic             req_doze = 1'b0;
  logic             req_boff_exit = 1'b0;
  logic             clk_stop = 1'b0;
  logic             tx_busy = 1'b0;
  logic             tx_end = 1'b0;
  logic [TEC_W-1:0] tec = '0;
  logic             idle11 = 1'b0;
  logic             stat_init, stat_busoff, regs_clr, wr_lock, comm_en;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  can_mode_seq #(.TEC_W(TEC_W), .TEC_LIMIT(255), .SIGHTINGS(128)) dut (
    .clk(clk), .rst(rst), .req_init(req_init), .req_doze(req_doze),
    .req_boff_exit(req_boff_exit), .clk_stop(clk_stop), .tx_busy(tx_busy),
    .tx_end(tx_end), .tec(tec), .idle11(idle11), .stat_init(stat_init),
    .stat_busoff(stat_busoff), .regs_clr(regs_clr), .wr_lock(wr_lock),
    .comm_en(comm_en)
  );

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
    end
  endtask

  // expected flags {stat_init, stat_busoff, comm_en, wr_lock, regs_clr}
  task automatic chk_all(input string req, input logic i, input logic b,
                         input logic c, input logic l, input logic r);
    chk(req, "stat_init", stat_init, i);
    chk(req, "stat_busoff", stat_busoff, b);
    chk(req, "comm_en", comm_en, c);
    chk(req, "wr_lock", wr_lock, l);
    chk(req, "regs_clr", regs_clr, r);
  endtask

  task automatic go_active();
    req_init = 1'b0; req_doze = 1'b0;
    step();
  endtask

  task automatic t_sys_reset();
    rst = 1'b1; req_init = 1'b1;
    step(2);
    chk_all("R1", 1, 0, 0, 1, 1);
    rst = 1'b0;
    step();
    chk_all("R1", 1, 0, 0, 1, 0);
  endtask

  task automatic t_to_active();
    go_active();
    chk_all("R2", 0, 0, 1, 0, 0);
  endtask

  task automatic t_init_now();
    req_init = 1'b1; tx_busy = 1'b0;
    step();
    chk_all("R3", 1, 0, 0, 1, 1);
    step();
    chk_all("R3", 1, 0, 0, 1, 0);
  endtask

  task automatic t_init_waits_tx();
    go_active();
    tx_busy = 1'b1; req_init = 1'b1;
    step(3);
    chk_all("R4", 0, 0, 1, 0, 0);
    tx_end = 1'b1;
    step();
    tx_end = 1'b0; tx_busy = 1'b0;
    chk_all("R4", 1, 0, 0, 1, 1);
  endtask

  task automatic t_doze_paths();
    req_init = 1'b0; req_doze = 1'b1;
    step();
    chk_all("R5", 0, 0, 0, 0, 0);
    clk_stop = 1'b1;
    step();
    req_init = 1'b1; req_doze = 1'b0;
    step(2);
    chk("R7", "stat_init in deep doze", stat_init, 1'b0);
    clk_stop = 1'b0;
    step();
    chk("R7", "stat_init after wake", stat_init, 1'b0);
    step();
    chk("R6", "stat_init from doze", stat_init, 1'b1);
    req_init = 1'b0; req_doze = 1'b1;
    step();
    chk("R5", "stat_init in doze", stat_init, 1'b0);
    req_init = 1'b1; req_doze = 1'b0;
    step();
    chk_all("R6", 1, 0, 0, 1, 1);
  endtask

  task automatic t_busoff_count();
    go_active();
    tec = 9'd255;
    step();
    chk("R8", "comm_en at tec 255", comm_en, 1'b1);
    tec = 9'd256; req_init = 1'b1;
    step();
    chk_all("R8", 0, 1, 0, 0, 0);
    req_init = 1'b0; tec = '0;
    idle11 = 1'b1;
    step(127);
    chk("R9", "stat_busoff after 127", stat_busoff, 1'b1);
    step();
    idle11 = 1'b0;
    chk_all("R9", 0, 0, 1, 0, 0);
  endtask

  task automatic t_busoff_force();
    tec = 9'd300;
    step();
    tec = '0;
    chk("R10", "stat_busoff", stat_busoff, 1'b1);
    step(3);
    chk("R10", "stat_busoff held", stat_busoff, 1'b1);
    req_boff_exit = 1'b1;
    step();
    req_boff_exit = 1'b0;
    chk_all("R10", 0, 0, 1, 0, 0);
  endtask

  task automatic t_busoff_init();
    tec = 9'd300;
    step();
    tec = '0;
    idle11 = 1'b1;
    step(100);
    idle11 = 1'b0;
    req_init = 1'b1; req_boff_exit = 1'b1;
    step();
    req_boff_exit = 1'b0;
    chk_all("R11", 1, 0, 0, 1, 1);
    go_active();
    tec = 9'd300;
    step();
    tec = '0;
    idle11 = 1'b1;
    step(127);
    chk("R11", "count restarted", stat_busoff, 1'b1);
    step();
    idle11 = 1'b0;
    chk("R11", "exit on 128th", comm_en, 1'b1);
  endtask

  task automatic t_exclusive();
    chk("R12", "flags exclusive",
        logic'($countones({stat_init, stat_busoff, comm_en}) <= 1), 1'b1);
    chk("R12", "clear only in init", logic'(!regs_clr || stat_init), 1'b1);
  endtask

  initial begin
    @(negedge clk);
    t_sys_reset();
    t_to_active();
    t_exclusive();
    t_init_now();
    t_init_waits_tx();
    t_doze_paths();
    t_busoff_count();
    t_exclusive();
    t_busoff_force();
    t_busoff_init();
    t_exclusive();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule